// File: doc/BRIEF.md
# Double Linefill Request Generator

This block sits on the miss path of a level-2 cache, in front of a 64-bit downstream read bus. For each miss it takes the requested address, the kind and length of the burst that caused the miss, and a prefetch flag. From these and a small set of configuration inputs it decides whether to fetch only the missing 32-byte line (four 64-bit beats) or a pair of lines (eight beats). It then emits one downstream read command giving the address, WRAP or INCR, and the encoded length.

When a pair is fetched, the second line is fetched speculatively. While the burst is in flight the block sends the tag array one lookup for that line. As beats return, the first line's beats pass straight to the fill buffer. The second line's beats wait in a four-entry buffer until the lookup answers. A miss lets them through and they are allocated; a hit drops them. Only one miss is handled at a time, and the request side uses a valid/ready handshake.

Top module: `dlf_gen`

## Requirements
- R1: In reset and right after it, `req_ready` is 1 and `dn_valid`, `lk_valid` and `fb_valid` are 0.
- R2: With `cfg_dbl_en` low, every accepted request gives a WRAP command (`dn_incr`=0) with `dn_len`=3 at the exact request address, and no lookup. `cfg_wrap_off` and `cfg_incr_en` have no effect.
- R3: A pair fetch is considered only if all of these hold: `req_wide`=1 (64-bit), `req_len`=3 (four beats), and `req_burst` is INCR (code 1) or WRAP (code 2). Code 0 (fixed) and code 3 never qualify. A request with `req_pref`=1 while `cfg_excl`=1 always gets a single fetch.
- R4: With `cfg_wrap_off` set, a qualifying request whose offset inside its line is not zero (address bits 4:3 not 00) gets a single WRAP fetch of length 3 at the exact address.
- R5: A qualifying request that is neither a single fetch under R4 nor an incrementing case under R6/R7 gets a WRAP command of length 7. Its address is the request address rounded down to 64 bytes. This covers `cfg_incr_en` off, or a request in the lower half of a 64-byte region (address bit 5 = 0).
- R6: With `cfg_incr_en` set, a qualifying request in the upper half (bit 5 = 1) gets an INCR command of length 7. Its address is the request address rounded down to 32 bytes.
- R7: If the R6 case would carry the second line into the next 4-Kbyte page (address bits 11:5 all ones), a single WRAP fetch of length 3 at the exact address is issued instead.
- R8: A pair fetch raises `lk_valid` for one cycle, in the same cycle as `dn_valid`. `lk_addr` is the 32-byte base of `dn_addr` plus 32. A single fetch raises no lookup, and `lk_done` is then ignored.
- R9: The first four returned beats appear on the fill output in arrival order with `fb_line`=0 and `fb_beat`=0..3.
- R10: For a pair fetch, the last four beats appear with `fb_line`=1 and `fb_beat`=0..3 if `lk_hit` was 0, and never appear if `lk_hit` was 1. This holds whether `lk_done` comes before, during or after those beats.
- R11: `req_ready` is 0 from the accepting edge until every beat has been routed. The command is a one-cycle pulse the cycle after acceptance. Beats offered while idle produce no fill output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_dbl_en | input | 1 | Enables pair fetches |
| cfg_wrap_off | input | 1 | Suppresses pair fetch for non-line-aligned requests |
| cfg_incr_en | input | 1 | Allows INCR pair fetch for upper-half requests |
| cfg_excl | input | 1 | Exclusive cache mode |
| req_valid | input | 1 | Miss request valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | AW | Miss byte address |
| req_burst | input | 2 | Incoming burst kind: 0 fixed, 1 INCR, 2 WRAP |
| req_len | input | LEN_W | Incoming beat count minus one |
| req_wide | input | 1 | Incoming transfer is 64-bit |
| req_pref | input | 1 | Request is a prefetch |
| dn_valid | output | 1 | Downstream read command pulse |
| dn_addr | output | AW | Downstream start address |
| dn_incr | output | 1 | 1 INCR, 0 WRAP |
| dn_len | output | LEN_W | Downstream beat count minus one |
| lk_valid | output | 1 | Second-line lookup pulse |
| lk_addr | output | AW | Second-line address |
| lk_done | input | 1 | Lookup result valid |
| lk_hit | input | 1 | Lookup result: second line present |
| rd_valid | input | 1 | Read beat valid |
| rd_data | input | DW | Read beat data |
| fb_valid | output | 1 | Beat to be allocated |
| fb_data | output | DW | Beat data |
| fb_line | output | 1 | 0 first line, 1 second line |
| fb_beat | output | 2 | Beat index within the line |

## Verification
The hardest state to reach is the lookup answer landing at every possible point relative to the returning beats. It can arrive before the first beat, in the middle of the first line, while second-line beats are already buffered, or only after all eight have arrived. The transaction task takes the beat index at which `lk_done` is pulsed as a parameter, including indices past the last beat, and mixes it with random gaps between beats. Addresses are biased toward the last 64 bytes of a page so the page-crossing fallback is hit often under incrementing mode.

// File: rtl/dlf_pkg.sv
package dlf_pkg;
  typedef enum logic [1:0] {
    BT_FIXED = 2'd0,
    BT_INCR  = 2'd1,
    BT_WRAP  = 2'd2
  } burst_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } state_t;
endpackage

// File: rtl/dlf_decide.sv
module dlf_decide
  import dlf_pkg::*;
#(
  parameter int AW     = 32,
  parameter int LINE_B = 32,
  parameter int PAGE_B = 4096,
  parameter int BEAT_B = 8,
  parameter int LEN_W  = 4
) (
  input  logic [AW-1:0]    addr,
  input  logic [1:0]       burst,
  input  logic [LEN_W-1:0] len,
  input  logic             wide,
  input  logic             pref,
  input  logic             excl,
  input  logic             en,
  input  logic             wrap_off,
  input  logic             incr_en,
  output logic             dbl,
  output logic [AW-1:0]    out_addr,
  output logic             out_incr,
  output logic [LEN_W-1:0] out_len,
  output logic [AW-1:0]    second_addr
);
  localparam int OFF_W  = $clog2(LINE_B);
  localparam int BO_W   = $clog2(BEAT_B);
  localparam int PG_W   = $clog2(PAGE_B);
  localparam int LBEATS = LINE_B / BEAT_B;
  localparam logic [LEN_W-1:0] SGL_LEN = LEN_W'(LBEATS - 1);
  localparam logic [LEN_W-1:0] DBL_LEN = LEN_W'(2 * LBEATS - 1);
  localparam logic [AW-1:0] LINE_MASK = ~AW'(LINE_B - 1);
  localparam logic [AW-1:0] PAIR_MASK = ~AW'(2 * LINE_B - 1);

  logic mid_nz, upper, page_last, kind_ok, qualify;

  always_comb begin
    mid_nz    = |addr[OFF_W-1:BO_W];
    upper     = addr[OFF_W];
    page_last = &addr[PG_W-1:OFF_W];
    kind_ok   = (burst == BT_INCR) || (burst == BT_WRAP);
    qualify   = en && wide && (len == SGL_LEN) && kind_ok && !(pref && excl);

    dbl      = 1'b0;
    out_addr = addr;
    out_incr = 1'b0;
    out_len  = SGL_LEN;
    if (qualify && !(wrap_off && mid_nz)) begin
      if (incr_en && upper) begin
        if (!page_last) begin
          dbl      = 1'b1;
          out_addr = addr & LINE_MASK;
          out_incr = 1'b1;
          out_len  = DBL_LEN;
        end
      end else begin
        dbl      = 1'b1;
        out_addr = addr & PAIR_MASK;
        out_len  = DBL_LEN;
      end
    end
    second_addr = (out_addr & LINE_MASK) + AW'(LINE_B);
  end
endmodule

// File: rtl/dlf_beat_buf.sv
module dlf_beat_buf #(
  parameter int DW    = 64,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic          empty
);
  localparam int PW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [PW:0]   cnt_q, cnt_d;

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_ent
      always_ff @(posedge clk) begin
        if (push && (wr_q == PW'(gi))) mem[gi] <= din;
      end
    end
  endgenerate

  always_comb begin
    wr_d  = push ? wr_q + 1'b1 : wr_q;
    rd_d  = pop ? rd_q + 1'b1 : rd_q;
    cnt_d = cnt_q + (PW+1)'(push) - (PW+1)'(pop);
    dout  = mem[rd_q];
    empty = (cnt_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/dlf_gen.sv
module dlf_gen
  import dlf_pkg::*;
#(
  parameter int AW     = 32,
  parameter int DW     = 64,
  parameter int LINE_B = 32,
  parameter int PAGE_B = 4096,
  parameter int LEN_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_dbl_en,
  input  logic             cfg_wrap_off,
  input  logic             cfg_incr_en,
  input  logic             cfg_excl,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [AW-1:0]    req_addr,
  input  logic [1:0]       req_burst,
  input  logic [LEN_W-1:0] req_len,
  input  logic             req_wide,
  input  logic             req_pref,
  output logic             dn_valid,
  output logic [AW-1:0]    dn_addr,
  output logic             dn_incr,
  output logic [LEN_W-1:0] dn_len,
  output logic             lk_valid,
  output logic [AW-1:0]    lk_addr,
  input  logic             lk_done,
  input  logic             lk_hit,
  input  logic             rd_valid,
  input  logic [DW-1:0]    rd_data,
  output logic             fb_valid,
  output logic [DW-1:0]    fb_data,
  output logic             fb_line,
  output logic [1:0]       fb_beat
);
  localparam int BEAT_B = DW / 8;
  localparam int LBEATS = LINE_B / BEAT_B;
  localparam int BI_W   = $clog2(LBEATS);
  localparam int CNT_W  = $clog2(2 * LBEATS) + 1;

  // decision for the request at the port
  logic             dec_dbl, dec_incr;
  logic [AW-1:0]    dec_addr, dec_second;
  logic [LEN_W-1:0] dec_len;

  dlf_decide #(
    .AW(AW), .LINE_B(LINE_B), .PAGE_B(PAGE_B), .BEAT_B(BEAT_B), .LEN_W(LEN_W)
  ) u_decide (
    .addr(req_addr), .burst(req_burst), .len(req_len), .wide(req_wide),
    .pref(req_pref), .excl(cfg_excl), .en(cfg_dbl_en), .wrap_off(cfg_wrap_off),
    .incr_en(cfg_incr_en), .dbl(dec_dbl), .out_addr(dec_addr),
    .out_incr(dec_incr), .out_len(dec_len), .second_addr(dec_second)
  );

  // second-line holding buffer
  logic          push, pop, buf_empty;
  logic [DW-1:0] buf_dout;

  dlf_beat_buf #(.DW(DW), .DEPTH(LBEATS)) u_buf (
    .clk(clk), .rst_n(rst_n), .push(push), .din(rd_data),
    .pop(pop), .dout(buf_dout), .empty(buf_empty)
  );

  state_t           st_q, st_d;
  logic             dbl_q, dbl_d, known_q, known_d, hit_q, hit_d;
  logic [CNT_W-1:0] rx_q, rx_d, total;
  logic [BI_W-1:0]  pidx_q, pidx_d;
  logic             accept, beat_in, first, lk_take, done, cmd_en, fb_en;
  logic             fb_valid_d, fb_line_d;
  logic [DW-1:0]    fb_data_d;
  logic [BI_W-1:0]  fb_beat_d;
  logic             dn_valid_q, lk_valid_q, dn_incr_q, fb_valid_q, fb_line_q;
  logic [AW-1:0]    dn_addr_q, lk_addr_q;
  logic [LEN_W-1:0] dn_len_q;
  logic [DW-1:0]    fb_data_q;
  logic [BI_W-1:0]  fb_beat_q;

  // next-state logic
  always_comb begin
    total   = dbl_q ? CNT_W'(2 * LBEATS) : CNT_W'(LBEATS);
    accept  = (st_q == ST_IDLE) && req_valid;
    beat_in = (st_q == ST_BUSY) && rd_valid && (rx_q < total);
    first   = rx_q < CNT_W'(LBEATS);
    push    = beat_in && !first;
    pop     = !buf_empty && known_q;
    lk_take = (st_q == ST_BUSY) && dbl_q && !known_q && lk_done;
    done    = (st_q == ST_BUSY) && (rx_q == total) && buf_empty && (known_q || !dbl_q);

    st_d    = st_q;
    dbl_d   = dbl_q;
    known_d = known_q;
    hit_d   = hit_q;
    rx_d    = rx_q;
    pidx_d  = pidx_q;
    if (accept) begin
      st_d    = ST_BUSY;
      dbl_d   = dec_dbl;
      known_d = !dec_dbl;
      hit_d   = 1'b0;
      rx_d    = '0;
      pidx_d  = '0;
    end else begin
      if (done)    st_d = ST_IDLE;
      if (beat_in) rx_d = rx_q + 1'b1;
      if (pop)     pidx_d = pidx_q + 1'b1;
      if (lk_take) begin
        known_d = 1'b1;
        hit_d   = lk_hit;
      end
    end

    cmd_en     = accept || dn_valid_q || lk_valid_q;
    fb_valid_d = (beat_in && first) || (pop && !hit_q);
    fb_en      = fb_valid_d || fb_valid_q;
    fb_data_d  = (beat_in && first) ? rd_data : buf_dout;
    fb_line_d  = !(beat_in && first);
    fb_beat_d  = (beat_in && first) ? rx_q[BI_W-1:0] : pidx_q;
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      dbl_q   <= 1'b0;
      known_q <= 1'b1;
      hit_q   <= 1'b0;
      rx_q    <= '0;
      pidx_q  <= '0;
    end else begin
      st_q    <= st_d;
      dbl_q   <= dbl_d;
      known_q <= known_d;
      hit_q   <= hit_d;
      rx_q    <= rx_d;
      pidx_q  <= pidx_d;
    end
  end

  // command and lookup outputs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dn_valid_q <= 1'b0;
      lk_valid_q <= 1'b0;
      dn_addr_q  <= '0;
      dn_incr_q  <= 1'b0;
      dn_len_q   <= '0;
      lk_addr_q  <= '0;
    end else if (cmd_en) begin
      dn_valid_q <= accept;
      lk_valid_q <= accept && dec_dbl;
      if (accept) begin
        dn_addr_q <= dec_addr;
        dn_incr_q <= dec_incr;
        dn_len_q  <= dec_len;
        lk_addr_q <= dec_second;
      end
    end
  end

  // fill-buffer outputs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fb_valid_q <= 1'b0;
      fb_data_q  <= '0;
      fb_line_q  <= 1'b0;
      fb_beat_q  <= '0;
    end else if (fb_en) begin
      fb_valid_q <= fb_valid_d;
      fb_data_q  <= fb_data_d;
      fb_line_q  <= fb_line_d;
      fb_beat_q  <= fb_beat_d;
    end
  end

  assign req_ready = (st_q == ST_IDLE);
  assign dn_valid  = dn_valid_q;
  assign dn_addr   = dn_addr_q;
  assign dn_incr   = dn_incr_q;
  assign dn_len    = dn_len_q;
  assign lk_valid  = lk_valid_q;
  assign lk_addr   = lk_addr_q;
  assign fb_valid  = fb_valid_q;
  assign fb_data   = fb_data_q;
  assign fb_line   = fb_line_q;
  assign fb_beat   = 2'(fb_beat_q);
endmodule

// File: rtl/dlf_gen_chk.sv
module dlf_gen_chk #(
  parameter int LEN_W   = 4,
  parameter int SGL_LEN = 3,
  parameter int DBL_LEN = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             cfg_dbl_en,
  input logic             dn_valid,
  input logic             dn_incr,
  input logic [LEN_W-1:0] dn_len,
  input logic             lk_valid,
  input logic             fb_valid
);
  // R11
  cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |=> !dn_valid);

  // R11
  cmd_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_ready) |-> dn_valid && $past(req_valid));

  // R11
  fill_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fb_valid |-> !req_ready);

  // R8
  lookup_with_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> dn_valid && (dn_len == LEN_W'(DBL_LEN)));

  // R2
  disabled_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && $past(!cfg_dbl_en)) |-> (dn_len == LEN_W'(SGL_LEN)) && !dn_incr && !lk_valid);

  // R6
  incr_is_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && dn_incr) |-> lk_valid);
endmodule

bind dlf_gen dlf_gen_chk #(
  .LEN_W(LEN_W), .SGL_LEN(LINE_B / (DW / 8) - 1), .DBL_LEN(2 * (LINE_B / (DW / 8)) - 1)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .cfg_dbl_en(cfg_dbl_en), .dn_valid(dn_valid), .dn_incr(dn_incr),
  .dn_len(dn_len), .lk_valid(lk_valid), .fb_valid(fb_valid)
);

// File: tb/dlf_gen_bench.sv
module dlf_gen_bench;
  localparam int AW = 32;
  localparam int DW = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_dbl_en = 0, cfg_wrap_off = 0, cfg_incr_en = 0, cfg_excl = 0;
  logic          req_valid = 0, req_wide = 0, req_pref = 0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_burst = '0;
  logic [3:0]    req_len = '0;
  logic          lk_done = 0, lk_hit = 0, rd_valid = 0;
  logic [DW-1:0] rd_data = '0;
  logic          req_ready, dn_valid, dn_incr, lk_valid, fb_valid, fb_line;
  logic [AW-1:0] dn_addr, lk_addr;
  logic [3:0]    dn_len;
  logic [DW-1:0] fb_data;
  logic [1:0]    fb_beat;

  dlf_gen u_dlf_gen (
    .clk(clk), .rst_n(rst_n), .cfg_dbl_en(cfg_dbl_en), .cfg_wrap_off(cfg_wrap_off),
    .cfg_incr_en(cfg_incr_en), .cfg_excl(cfg_excl), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .req_burst(req_burst),
    .req_len(req_len), .req_wide(req_wide), .req_pref(req_pref),
    .dn_valid(dn_valid), .dn_addr(dn_addr), .dn_incr(dn_incr), .dn_len(dn_len),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_done(lk_done), .lk_hit(lk_hit),
    .rd_valid(rd_valid), .rd_data(rd_data), .fb_valid(fb_valid),
    .fb_data(fb_data), .fb_line(fb_line), .fb_beat(fb_beat)
  );

  always #10 clk = ~clk;

  int errs = 0;
  int checks = 0;
  int cyc = 0;
  int tag = 0;

  logic [DW-1:0] rec_data [16];
  logic          rec_line [16];
  logic [1:0]    rec_beat [16];
  int            rec_n = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && fb_valid) begin
      if (rec_n < 16) begin
        rec_data[rec_n] = fb_data;
        rec_line[rec_n] = fb_line;
        rec_beat[rec_n] = fb_beat;
      end
      rec_n++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errs++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  // independent model of the command choice
  function automatic void model(input logic [AW-1:0] a, input logic [1:0] b,
      input logic [3:0] l, input bit w, input bit p, input bit en, input bit wo,
      input bit inc, input bit ex, output bit dbl, output logic [AW-1:0] ea,
      output bit ei, output string rq);
    bit lower_nz, upper;
    lower_nz = (a[4:3] != 2'b00);
    upper = a[5];
    dbl = 0; ea = a; ei = 0;
    if (!en) begin rq = "R2"; return; end
    if (!w || l != 4'd3 || !(b == 2'd1 || b == 2'd2) || (p && ex)) begin
      rq = "R3"; return;
    end
    if (wo && lower_nz) begin rq = "R4"; return; end
    if (inc && upper) begin
      if (a[11:5] == 7'h7F) begin rq = "R7"; return; end
      rq = "R6"; dbl = 1; ea = {a[AW-1:5], 5'b0}; ei = 1; return;
    end
    rq = "R5"; dbl = 1; ea = {a[AW-1:6], 6'b0};
  endfunction

  task automatic txn(input logic [AW-1:0] a, input logic [1:0] b, input logic [3:0] l,
      input bit w, input bit p, input bit en, input bit wo, input bit inc, input bit ex,
      input bit hit, input int lk_at, input int gap_max);
    bit dbl, ei;
    logic [AW-1:0] ea;
    string rq;
    int nb, exp_n;
    model(a, b, l, w, p, en, wo, inc, ex, dbl, ea, ei, rq);
    while (!req_ready) @(negedge clk);
    tag++;
    cfg_dbl_en = en; cfg_wrap_off = wo; cfg_incr_en = inc; cfg_excl = ex;
    req_addr = a; req_burst = b; req_len = l; req_wide = w; req_pref = p;
    req_valid = 1;
    rec_n = 0;
    @(negedge clk);
    req_valid = 0;
    chk(dn_valid == 1'b1, "R11", "command pulse", dn_valid, 1);
    chk(req_ready == 1'b0, "R11", "busy after accept", req_ready, 0);
    chk(dn_addr == ea, rq, "command address", dn_addr, ea);
    chk(dn_len == (dbl ? 4'd7 : 4'd3), rq, "command length", dn_len, dbl ? 7 : 3);
    chk(dn_incr == ei, rq, "command kind", dn_incr, ei);
    chk(lk_valid == dbl, "R8", "lookup pulse", lk_valid, dbl);
    if (dbl) chk(lk_addr == {ea[AW-1:5], 5'b0} + 32'd32, "R8", "lookup address",
                 lk_addr, {ea[AW-1:5], 5'b0} + 32'd32);
    nb = dbl ? 8 : 4;
    for (int i = 0; i < nb; i++) begin
      repeat ($urandom_range(gap_max, 0)) @(negedge clk);
      rd_valid = 1;
      rd_data = {32'(tag), 32'(i)};
      if (lk_at == i) begin lk_done = 1; lk_hit = hit; end
      @(negedge clk);
      rd_valid = 0;
      lk_done = 0;
    end
    if (lk_at >= nb) begin
      repeat (lk_at - nb + 1) @(negedge clk);
      lk_done = 1; lk_hit = hit;
      @(negedge clk);
      lk_done = 0;
    end
    while (!req_ready) @(negedge clk);
    exp_n = (dbl && !hit) ? 8 : 4;
    chk(rec_n == exp_n, dbl ? "R10" : "R9", "fill beat count", rec_n, exp_n);
    for (int i = 0; i < exp_n && i < rec_n && i < 16; i++) begin
      chk(rec_data[i] == {32'(tag), 32'(i)} && rec_line[i] == (i >= 4) &&
          rec_beat[i] == 2'(i % 4), (i < 4) ? "R9" : "R10", "fill beat data",
          rec_data[i], {32'(tag), 32'(i)});
    end
  endtask

  task automatic idle_noise();
    rec_n = 0;
    rd_valid = 1; rd_data = 64'hDEAD;
    lk_done = 1; lk_hit = 0;
    repeat (3) @(negedge clk);
    rd_valid = 0; lk_done = 0;
    repeat (2) @(negedge clk);
    chk(rec_n == 0, "R11", "idle beats ignored", rec_n, 0);
    chk(req_ready == 1'b1, "R11", "still ready when idle", req_ready, 1);
  endtask

  initial begin
    void'($urandom(32'h1F2E3D4C));
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1", "reset ready", req_ready, 1);
    chk(dn_valid == 1'b0 && lk_valid == 1'b0 && fb_valid == 1'b0, "R1", "reset pulses",
        {dn_valid, lk_valid, fb_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1'b1 && !dn_valid && !fb_valid, "R1", "after reset", req_ready, 1);

    // directed corners: addr, burst, len, wide, pref, en, wrap_off, incr, excl, hit, lk_at, gap
    txn(32'h1000_0028, 2'd2, 4'd3, 1, 0, 0, 1, 1, 0, 0, 0, 0);   // R2 other bits ignored
    txn(32'h1000_0040, 2'd2, 4'd3, 1, 0, 1, 0, 0, 0, 0, 0, 1);   // R5 aligned
    txn(32'h1000_0068, 2'd2, 4'd3, 1, 0, 1, 0, 0, 0, 1, 2, 0);   // R5 rounded, hit
    txn(32'h1000_0068, 2'd2, 4'd3, 1, 0, 1, 1, 0, 0, 0, 0, 0);   // R4
    txn(32'h1000_0060, 2'd1, 4'd3, 1, 0, 1, 1, 1, 0, 0, 9, 1);   // R6, late lookup
    txn(32'h1000_0078, 2'd2, 4'd3, 1, 0, 1, 0, 1, 0, 1, 11, 0);  // R6, late hit
    txn(32'h1000_0FF0, 2'd2, 4'd3, 1, 0, 1, 0, 1, 0, 0, 0, 0);   // R7 page end
    txn(32'h1000_0FD0, 2'd2, 4'd3, 1, 0, 1, 0, 1, 0, 0, 5, 0);   // R5 lower half near page end
    txn(32'h1000_0010, 2'd2, 4'd3, 1, 1, 1, 0, 0, 1, 0, 0, 0);   // R3 prefetch+exclusive
    txn(32'h1000_0010, 2'd0, 4'd3, 1, 0, 1, 0, 0, 0, 0, 0, 0);   // R3 fixed burst
    txn(32'h1000_0010, 2'd2, 4'd7, 1, 0, 1, 0, 0, 0, 0, 0, 0);   // R3 long burst
    txn(32'h1000_0010, 2'd2, 4'd3, 0, 0, 1, 0, 0, 0, 0, 0, 0);   // R3 narrow
    txn(32'h1000_0010, 2'd2, 4'd3, 1, 1, 1, 0, 0, 0, 0, 6, 2);   // R10 prefetch non-exclusive
    idle_noise();

    for (int n = 0; n < 300; n++) begin
      logic [AW-1:0] a;
      logic [1:0] b;
      int r;
      a = $urandom;
      if ($urandom_range(3, 0) == 0) a[11:0] = 12'hFC0 + 12'($urandom_range(7, 0) * 8);
      a[2:0] = 3'b000;
      r = $urandom_range(9, 0);
      b = (r < 7) ? 2'd2 : (r < 9) ? 2'd1 : 2'($urandom_range(3, 0));
      txn(a, b, ($urandom_range(9, 0) == 0) ? 4'd7 : 4'd3,
          $urandom_range(9, 0) != 0, $urandom_range(4, 0) == 0,
          $urandom_range(3, 0) != 0, 1'($urandom), 1'($urandom),
          $urandom_range(2, 0) == 0, 1'($urandom),
          $urandom_range(11, 0), $urandom_range(2, 0));
      if (n % 50 == 0) idle_noise();
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule